// File: doc/BRIEF.md
# Reset Supervisor with Duty-Cycled Supply Monitor

This block gathers every reason a processor core may need to be held in reset and turns them into one active-low core reset. There are four reasons: a supply failure or a fresh power-up, the external reset pin, a watchdog timeout request and a software-issued system reset request. While any of them is active the core is held. When the last one clears, the core is released and fetches from a fixed restart address. A sticky flag for each reason records what caused the most recent reset.

The supply comparator output is also used to build a power-on delay. After power-up the core is kept in reset for a minimum number of clock cycles. If the supply is still below its threshold when that delay runs out, the core is held until the supply comes good. To save power, the supply monitor can be duty-cycled. A 2-bit interval select either keeps the monitor on all the time or enables it for one slow-oscillator cycle out of every 2^E0, 2^(E0+1) or 2^(E0+2) cycles. With E0 = 10 and an oscillator near 8 kHz these intervals are roughly 128 ms, 256 ms and 512 ms.

The block runs on the system clock. The slow oscillator, the comparator and the external pin are asynchronous inputs and are synchronized on entry.

Top module: `rst_supervisor`

## Requirements
- R1: `core_rst_n` is low while `rst_n` is low and while any of the four causes is active. It returns high only after the last active cause has cleared.
- R2: `core_rst_n` falls on the first clock edge after `wdt_rst_req` or `sys_rst_req` is sampled high, and rises on the first edge after the last of them is sampled low. `ext_rst_n` (active low) passes through a two-stage synchronizer, so the core reset follows it three edges after it changes.
- R3: After power-up, or after the supply recovers, the core reset is held until `supply_ok` has been seen high through its two-stage synchronizer for POR_DELAY consecutive cycles. `core_rst_n` rises POR_DELAY+3 clock edges after `supply_ok` rises, or after `rst_n` rises when the supply is already good. It stays low indefinitely while `supply_ok` stays low.
- R4: A low supply seen while the monitor is enabled asserts power reset and restarts the power-on delay count from zero. With the monitor always on, `core_rst_n` falls four edges after `supply_ok` falls.
- R5: `restart_addr` always reads 16'h8000.
- R6: `cause_flags` bit 0 = power, bit 1 = external pin, bit 2 = watchdog, bit 3 = system request. A flag is set when its cause is active and is never cleared except by a power reset. While a power reset is active the flags read 4'b0001.
- R7: With `intv_sel` = 2'b00, `mon_en` is continuously high.
- R8: With `intv_sel` = 2'b01, 2'b10 or 2'b11, `mon_en` pulses high for exactly one slow-oscillator period, once every 2^E0, 2^(E0+1) or 2^(E0+2) oscillator periods respectively.
- R9: In duty-cycled mode, a supply drop while `mon_en` is low does not reset the core. The drop causes a power reset two edges after `mon_en` next rises.
- R10: While a power reset is active, `mon_en` is held high regardless of `intv_sel`.
- R11: A change of `intv_sel` restarts the interval count from zero. The first strobe of the new setting comes one full interval after the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low initialisation of the always-on logic (power-up) |
| osc_clk | input | 1 | Slow ring-oscillator clock, sampled as data |
| supply_ok | input | 1 | Comparator: supply above the power-on threshold (asynchronous) |
| ext_rst_n | input | 1 | External reset pin, active low (asynchronous) |
| wdt_rst_req | input | 1 | Watchdog reset request, level |
| sys_rst_req | input | 1 | Software system reset request, level |
| intv_sel | input | 2 | Monitor interval select: 00 always on, 01/10/11 duty-cycled |
| core_rst_n | output | 1 | Core reset, active low, registered |
| restart_addr | output | ADDR_W | Fetch address used after reset release |
| mon_en | output | 1 | Supply monitor enable |
| cause_flags | output | 4 | Sticky reset-cause flags |

## Verification
The hardest case to reach is a supply failure that falls inside the window where the duty-cycled monitor is off. The failure must go unseen for a while and then be caught by the next strobe. The bench measures the strobe period first. It then drops the supply on the cycle just after a strobe ends and checks that the core stays released for the whole gap before reset arrives two edges after the strobe. A second hard case is an interval change made while the old count sits far above the new limit. The bench lets the longest interval run about twenty oscillator periods before switching to the shortest one, so a counter that was not restarted would visibly overshoot.

// File: rtl/rst_sup_pkg.sv
// Package: shared constants and cause indices for the reset supervisor.
// Assumes: cause flag bit positions are fixed and visible to software.
package rst_sup_pkg;

    localparam int NUM_CAUSES = 4;

    // Bit positions of the causes inside the flag vector.
    typedef enum int unsigned {
        CAUSE_PWR = 0,
        CAUSE_EXT = 1,
        CAUSE_WDT = 2,
        CAUSE_SYS = 3
    } cause_e;

    localparam logic [15:0] RESTART_VEC = 16'h8000;

endpackage

// File: rtl/rst_sync.sv
// Module: rst_sync
// Multi-stage synchronizer for a vector of independent asynchronous bits.
// Assumes: each bit is sampled on its own; no coherence across bits is needed.
module rst_sync #(
    parameter int          W       = 1,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg [STAGES];

    // Shift the asynchronous inputs through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/por_ctrl.sv
// Module: por_ctrl
// Power reset generator. A saturating counter measures consecutive cycles of
// good supply; any low supply seen while the monitor is enabled clears it.
// Assumes: sup_ok is already synchronized; mon_on is high whenever power reset is active.
module por_ctrl #(
    parameter int DELAY = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sup_ok,
    input  logic mon_on,
    output logic pwr_rst
);

    localparam int CW = $clog2(DELAY + 1);
    localparam logic [CW-1:0] DONE = CW'(DELAY);

    logic [CW-1:0] cnt;

    // Restart on a sensed fault, otherwise count up to the delay and hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (mon_on && !sup_ok) begin
            cnt <= '0;
        end else if (cnt != DONE) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign pwr_rst = (cnt != DONE);

endmodule

// File: rtl/mon_interval.sv
// Module: mon_interval
// Generates the duty-cycled supply-monitor enable from the slow oscillator.
// The strobe lasts from one oscillator rising edge to the next.
// Assumes: osc_s is synchronized and much slower than clk; sel comes from the clk domain.
module mon_interval #(
    parameter int EXP0 = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       osc_s,
    input  logic [1:0] sel,
    output logic       duty_en
);

    localparam int CW = EXP0 + 2;

    logic          osc_d;
    logic          tick;
    logic [1:0]    sel_q;
    logic [CW-1:0] cnt;
    logic [CW-1:0] lim;
    logic          strb;

    assign tick = osc_s & ~osc_d;

    // Terminal count: 2^(EXP0+sel-1)-1 for sel 1..3.
    always_comb lim = {CW{1'b1}} >> (2'd3 - sel_q);

    // Track the selection, count oscillator edges and produce the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            osc_d <= 1'b0;
            sel_q <= 2'd0;
            cnt   <= '0;
            strb  <= 1'b0;
        end else begin
            osc_d <= osc_s;
            if (sel != sel_q) begin
                sel_q <= sel;
                cnt   <= '0;
                strb  <= 1'b0;
            end else if (tick) begin
                if (cnt == lim) begin
                    cnt  <= '0;
                    strb <= 1'b1;
                end else begin
                    cnt  <= cnt + 1'b1;
                    strb <= 1'b0;
                end
            end
        end
    end

    assign duty_en = (sel_q == 2'd0) | strb;

endmodule

// File: rtl/rst_supervisor.sv
// Module: rst_supervisor (top)
// Merges power, pin, watchdog and software reset causes into one registered
// core reset, records sticky cause flags and drives the supply-monitor enable.
// Assumes: rst_n is the always-on domain power-up initialisation.
module rst_supervisor
    import rst_sup_pkg::*;
#(
    parameter int                POR_DELAY    = 4096,
    parameter int                INTV_EXP0    = 10,
    parameter int                SYNC_STAGES  = 2,
    parameter int                ADDR_W       = 16,
    parameter logic [ADDR_W-1:0] RESTART_ADDR = ADDR_W'(RESTART_VEC)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  osc_clk,
    input  logic                  supply_ok,
    input  logic                  ext_rst_n,
    input  logic                  wdt_rst_req,
    input  logic                  sys_rst_req,
    input  logic [1:0]            intv_sel,
    output logic                  core_rst_n,
    output logic [ADDR_W-1:0]     restart_addr,
    output logic                  mon_en,
    output logic [NUM_CAUSES-1:0] cause_flags
);

    localparam int SYNC_W = 3;
    localparam logic [NUM_CAUSES-1:0] PWR_ONLY = NUM_CAUSES'(1) << CAUSE_PWR;

    logic [SYNC_W-1:0]     async_in;
    logic [SYNC_W-1:0]     sync_out;
    logic                  ext_s;
    logic                  sup_s;
    logic                  osc_s;
    logic                  pwr_rst;
    logic                  duty_en;
    logic [NUM_CAUSES-1:0] cause_now;

    assign async_in = {osc_clk, supply_ok, ext_rst_n};

    rst_sync #(
        .W       (SYNC_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL ('0)
    ) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (async_in),
        .q     (sync_out)
    );

    assign ext_s = sync_out[0];
    assign sup_s = sync_out[1];
    assign osc_s = sync_out[2];

    mon_interval #(
        .EXP0 (INTV_EXP0)
    ) intv_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .osc_s   (osc_s),
        .sel     (intv_sel),
        .duty_en (duty_en)
    );

    por_ctrl #(
        .DELAY (POR_DELAY)
    ) por_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .sup_ok  (sup_s),
        .mon_on  (mon_en),
        .pwr_rst (pwr_rst)
    );

    // Monitor stays on throughout a power reset so recovery is seen.
    assign mon_en = pwr_rst | duty_en;

    // Collect the currently active causes.
    always_comb begin
        cause_now            = '0;
        cause_now[CAUSE_PWR] = pwr_rst;
        cause_now[CAUSE_EXT] = ~ext_s;
        cause_now[CAUSE_WDT] = wdt_rst_req;
        cause_now[CAUSE_SYS] = sys_rst_req;
    end

    // Register the merged core reset.
    always_ff @(posedge clk) begin
        if (!rst_n) core_rst_n <= 1'b0;
        else        core_rst_n <= ~|cause_now;
    end

    // Sticky flags: a power reset overwrites, other causes accumulate.
    always_ff @(posedge clk) begin
        if (!rst_n)       cause_flags <= PWR_ONLY;
        else if (pwr_rst) cause_flags <= PWR_ONLY;
        else              cause_flags <= cause_flags | cause_now;
    end

    assign restart_addr = RESTART_ADDR;

endmodule

// File: rtl/rst_supervisor_chk.sv
// Module: rst_supervisor_chk
// Port-level temporal checks for the reset supervisor, bound to the top.
// Assumes: requests are levels sampled on clk.
module rst_supervisor_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ext_rst_n,
    input logic       wdt_rst_req,
    input logic       sys_rst_req,
    input logic [1:0] intv_sel,
    input logic       core_rst_n,
    input logic       mon_en,
    input logic [3:0] cause_flags
);

    assert_wdt_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_rst_req |=> !core_rst_n);

    assert_sys_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_req |=> !core_rst_n);

    assert_ext_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ext_rst_n, 3) == 1'b0) |-> !core_rst_n);

    assert_flags_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(core_rst_n) && core_rst_n)
            |-> ((cause_flags & $past(cause_flags)) == $past(cause_flags)));

    assert_mon_always_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (intv_sel == 2'b00 && $past(intv_sel) == 2'b00) |-> mon_en);

endmodule

bind rst_supervisor rst_supervisor_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .ext_rst_n   (ext_rst_n),
    .wdt_rst_req (wdt_rst_req),
    .sys_rst_req (sys_rst_req),
    .intv_sel    (intv_sel),
    .core_rst_n  (core_rst_n),
    .mon_en      (mon_en),
    .cause_flags (cause_flags)
);

// File: tb/rst_supervisor_tb_top.sv
// Bench for rst_supervisor: small delay and interval settings, expected
// cycle counts derived from the requirements.
module rst_supervisor_tb_top;

    localparam int D    = 20;   // power-on delay
    localparam int E0   = 3;    // base interval exponent
    localparam int OSCH = 4;    // oscillator half period in clk cycles
    localparam int P    = 2 * OSCH;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       osc_clk = 1'b0;
    logic       supply_ok = 1'b1;
    logic       ext_rst_n = 1'b1;
    logic       wdt_rst_req = 1'b0;
    logic       sys_rst_req = 1'b0;
    logic [1:0] intv_sel = 2'b00;
    logic       core_rst_n;
    logic [15:0] restart_addr;
    logic       mon_en;
    logic [3:0] cause_flags;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    rst_supervisor #(
        .POR_DELAY (D),
        .INTV_EXP0 (E0)
    ) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .osc_clk      (osc_clk),
        .supply_ok    (supply_ok),
        .ext_rst_n    (ext_rst_n),
        .wdt_rst_req  (wdt_rst_req),
        .sys_rst_req  (sys_rst_req),
        .intv_sel     (intv_sel),
        .core_rst_n   (core_rst_n),
        .restart_addr (restart_addr),
        .mon_en       (mon_en),
        .cause_flags  (cause_flags)
    );

    always #10 clk = ~clk;  // 50 MHz

    initial begin
        forever begin
            repeat (OSCH) @(negedge clk);
            osc_clk = ~osc_clk;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic chk_rng(input string req, input string what, input int act,
                           input int lo, input int hi);
        checks++;
        if (act < lo || act > hi) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d..%0d", req, what, act, lo, hi);
        end
    endtask

    // Count clock edges until core_rst_n takes the wanted value.
    task automatic edges_core(input logic want, output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (core_rst_n !== want && n < 5000);
    endtask

    // Count cycles until the next rising transition of mon_en.
    task automatic wait_mon_rise(output int n);
        logic prev;
        prev = mon_en;
        n = 0;
        forever begin
            @(negedge clk);
            n++;
            if ((mon_en && !prev) || n > 5000) break;
            prev = mon_en;
        end
    endtask

    task automatic mon_width(output int n);
        n = 0;
        while (mon_en && n < 5000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        int n;
        int bad;
        int w;
        int per;

        // Reset state (R1, R5, R6)
        repeat (5) @(negedge clk);
        chk("R1", "core reset during rst_n", core_rst_n, 0);
        chk("R6", "flags during rst_n", cause_flags, 4'b0001);
        chk("R5", "restart address", restart_addr, 16'h8000);

        // Fast supply: release D+3 edges after rst_n (R3)
        rst_n = 1'b1;
        edges_core(1'b1, n);
        chk("R3", "release after fast power-up", n, D + 3);
        chk("R6", "flags after power-up", cause_flags, 4'b0001);

        // Slow supply: held while supply low, then D+3 after rise (R3)
        rst_n = 1'b0;
        supply_ok = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        bad = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (core_rst_n) bad++;
        end
        chk("R3", "cycles released with supply low", bad, 0);
        supply_ok = 1'b1;
        repeat (10) @(negedge clk);
        // Dip during the delay count restarts it (R4)
        supply_ok = 1'b0;
        repeat (4) @(negedge clk);
        supply_ok = 1'b1;
        edges_core(1'b1, n);
        chk("R4", "release after dip restarts count", n, D + 3);

        // External pin through synchronizer (R2, R6)
        ext_rst_n = 1'b0;
        edges_core(1'b0, n);
        chk("R2", "ext assert latency", n, 3);
        repeat (4) @(negedge clk);
        ext_rst_n = 1'b1;
        edges_core(1'b1, n);
        chk("R2", "ext release latency", n, 3);
        chk("R6", "flags after ext", cause_flags, 4'b0011);

        // Watchdog request (R2, R6)
        wdt_rst_req = 1'b1;
        edges_core(1'b0, n);
        chk("R2", "wdt assert latency", n, 1);
        repeat (5) @(negedge clk);
        wdt_rst_req = 1'b0;
        edges_core(1'b1, n);
        chk("R2", "wdt release latency", n, 1);
        chk("R6", "flags after wdt", cause_flags, 4'b0111);

        // Overlapping causes: release only after the last clears (R1)
        wdt_rst_req = 1'b1;
        @(negedge clk);
        sys_rst_req = 1'b1;
        @(negedge clk);
        wdt_rst_req = 1'b0;
        bad = 0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (core_rst_n) bad++;
        end
        chk("R1", "released while sys request active", bad, 0);
        sys_rst_req = 1'b0;
        edges_core(1'b1, n);
        chk("R1", "release after last cause", n, 1);
        chk("R6", "flags after sys", cause_flags, 4'b1111);

        // Always-on monitor catches a drop (R4, R6)
        supply_ok = 1'b0;
        edges_core(1'b0, n);
        chk("R4", "always-on fail latency", n, 4);
        chk("R6", "flags after power fail", cause_flags, 4'b0001);
        repeat (10) @(negedge clk);
        supply_ok = 1'b1;
        edges_core(1'b1, n);
        chk("R3", "release after power fail", n, D + 3);

        // Interval sweep (R7, R8)
        bad = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (!mon_en) bad++;
        end
        chk("R7", "cycles with monitor off in select 00", bad, 0);
        for (int s = 1; s < 4; s++) begin
            intv_sel = 2'(s);
            wait_mon_rise(n);
            for (int k = 0; k < 2; k++) begin
                mon_width(w);
                chk("R8", $sformatf("strobe width sel %0d", s), w, P);
                wait_mon_rise(n);
                per = w + n;
                chk("R8", $sformatf("strobe period sel %0d", s), per, (1 << (E0 + s - 1)) * P);
            end
        end

        // Selection change restarts the count (R11)
        intv_sel = 2'b11;
        wait_mon_rise(n);
        repeat (20 * P) @(negedge clk);
        intv_sel = 2'b01;
        wait_mon_rise(n);
        chk_rng("R11", "first strobe after select change", n,
                ((1 << E0) - 1) * P + 1, (1 << E0) * P + 2);

        // Drop hidden by duty cycling (R9, R10, R6, R3)
        wait_mon_rise(n);
        mon_width(w);
        supply_ok = 1'b0;
        bad = 0;
        n = 0;
        while (!mon_en && n < 5000) begin
            if (!core_rst_n) bad++;
            @(negedge clk);
            n++;
        end
        if (!core_rst_n) bad++;
        chk("R9", "core reset while monitor off", bad, 0);
        edges_core(1'b0, n);
        chk("R9", "fail latency after strobe", n, 2);
        bad = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (!mon_en) bad++;
        end
        chk("R10", "monitor off during power reset", bad, 0);
        chk("R6", "flags after duty-mode fail", cause_flags, 4'b0001);
        supply_ok = 1'b1;
        edges_core(1'b1, n);
        chk("R3", "release after duty-mode fail", n, D + 3);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule